// File: doc/BRIEF.md
# Aperture Remapping Translation Table

This block turns bus addresses that fall inside a fixed, page-granular aperture into physical addresses. Each 4 KiB page of the aperture has one entry in an on-chip table. An entry is either unmapped, or holds the physical page frame that the page lands on. Translation requests arrive on a valid/address pair. One cycle later the block answers with a result address and flags that tell a hit (the page is mapped), a fault (the page is in the aperture but unmapped) or a pass-through (the address is outside the aperture, or translation is switched off).

Software reaches the table only indirectly, through a single-cycle register port. It first writes an aperture byte address into a slot-select register; the slot is derived from that address, not from an index. It then writes or reads an entry-data register, which stores into or returns that slot. A control register switches translation on and off and reads back, so software can confirm that earlier writes have completed. The aperture base and the number of pages are parameters.

Top module: `aperture_remap`

## Requirements
- R1: After synchronous reset every table entry is zero, translation is disabled, the slot-select register is zero and all response outputs and `reg_rdata` are zero.
- R2: The control register sits at offset 0x24. Writing it sets the enable from bit 0 (1 = translate, 0 = bypass). Reading it returns the enable in bit 0, with bits 31:1 zero.
- R3: The slot-select register sits at offset 0x28. It stores all 32 bits written and reads them back unchanged.
- R4: The entry-data register sits at offset 0x2C. A write stores bit 31 as the valid flag and bits 30:12 as the page frame into slot (select − base) >> 12. A read returns that slot as {valid, frame, 12'h000}.
- R5: While the selected address lies outside the aperture, a write to the entry-data register changes no entry, and a read of it returns zero.
- R6: With translation enabled, a request whose address is inside the aperture and whose entry is valid is answered one cycle later with `rsp_hit`=1, `rsp_fault`=0 and `rsp_addr` = {1'b0, frame, request[11:0]}.
- R7: With translation enabled, a request inside the aperture whose entry is not valid is answered with `rsp_fault`=1, `rsp_hit`=0 and `rsp_addr`=0.
- R8: A request outside the aperture, or any request while translation is disabled, is answered with `rsp_addr` equal to the request address and both `rsp_hit` and `rsp_fault` at 0.
- R9: Writing an all-zero word into an entry unmaps its page, so later requests to that page fault.
- R10: The aperture covers the base up to base + PAGE_COUNT×4096 − 1 inclusive. Base − 1 and base + PAGE_COUNT×4096 lie outside it.
- R11: Each register read updates `reg_rdata` on the next clock edge, and the value holds until the next read. Offsets other than 0x24, 0x28 and 0x2C read as zero. `rsp_valid` equals the `req_valid` of the previous cycle. While it is low, `rsp_addr`, `rsp_hit` and `rsp_fault` are zero.
- R12: A request in the same cycle as a write to the entry it uses sees the entry as it was before that write. The same holds for the enable and the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_re` |
| req_valid | input | 1 | Translation request valid |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_addr | output | 32 | Translated or passed-through address |
| rsp_hit | output | 1 | Mapped page found |
| rsp_fault | output | 1 | In-aperture page not mapped |

## Verification
The assertions assume that the strobes and addresses on both ports are never unknown outside reset. They also assume that the aperture base is page aligned and that the aperture does not wrap past the top of the 32-bit space. No assumption is made about how register traffic and translation requests overlap: the same cycle may carry a read, a write and a request. The stimulus therefore mixes all three freely, including entry writes that collide with requests to the same page. It keeps every address defined, and it uses a page-aligned base whose aperture ends well below the top of the address space.

// File: rtl/aprm_pkg.sv
package aprm_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int REG_AW     = 8;
    localparam int PAGE_SHIFT = 12;
    localparam int VALID_BIT  = 31;
    localparam int FRAME_W    = VALID_BIT - PAGE_SHIFT;
    localparam int PAD_W      = ADDR_W - FRAME_W - PAGE_SHIFT;

    // Register offsets that software decodes.
    localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h24;
    localparam logic [REG_AW-1:0] OFS_SLOT  = 8'h28;
    localparam logic [REG_AW-1:0] OFS_ENTRY = 8'h2C;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_CTRL,
        RSEL_SLOT,
        RSEL_ENTRY
    } reg_sel_e;

    // One table slot: valid flag above a page frame.
    typedef struct packed {
        logic               valid;
        logic [FRAME_W-1:0] frame;
    } pte_t;

    // Registered translation answer.
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              fault;
        logic [ADDR_W-1:0] addr;
    } xl_rsp_t;

    function automatic reg_sel_e decode_reg(input logic [REG_AW-1:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_CTRL:  s = RSEL_CTRL;
            OFS_SLOT:  s = RSEL_SLOT;
            OFS_ENTRY: s = RSEL_ENTRY;
            default:   s = RSEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pte_to_word(input pte_t e);
        return {e.valid, e.frame, {PAGE_SHIFT{1'b0}}};
    endfunction

    function automatic pte_t word_to_pte(input logic [DATA_W-1:0] w);
        pte_t e;
        e.valid = w[VALID_BIT];
        e.frame = w[VALID_BIT-1:PAGE_SHIFT];
        return e;
    endfunction

    function automatic logic [ADDR_W-1:0] join_frame(
        input logic [FRAME_W-1:0]    frame,
        input logic [PAGE_SHIFT-1:0] offset
    );
        return {{PAD_W{1'b0}}, frame, offset};
    endfunction

endpackage

// File: rtl/aprm_range.sv
// Aperture membership test and slot index for one byte address.
module aprm_range
    import aprm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] APER_BASE  = 32'h4000_0000,
    parameter int                PAGE_COUNT = 32,
    parameter int                IDX_W      = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_aper,
    output logic [IDX_W-1:0]  idx
);

    // One extra bit so the end bound cannot wrap.
    localparam logic [ADDR_W:0] LO_X = {1'b0, APER_BASE};
    localparam logic [ADDR_W:0] HI_X = LO_X + ((ADDR_W + 1)'(PAGE_COUNT) << PAGE_SHIFT);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W:0]   addr_x;

    assign addr_x  = {1'b0, addr};
    assign offset  = addr - APER_BASE;
    assign in_aper = (addr_x >= LO_X) && (addr_x < HI_X);
    assign idx     = IDX_W'(offset >> PAGE_SHIFT);

endmodule

// File: rtl/aprm_table.sv
// Flop-based page table: one write port, N_RD combinational read ports.
module aprm_table
    import aprm_pkg::*;
#(
    parameter int PAGE_COUNT = 32,
    parameter int IDX_W      = 5,
    parameter int N_RD       = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [IDX_W-1:0]             widx,
    input  pte_t                         wpte,
    input  logic [N_RD-1:0][IDX_W-1:0]   ridx,
    output pte_t [N_RD-1:0]              rpte
);

    // Power-of-two slot space; slots past PAGE_COUNT stay zero forever.
    localparam int SLOTS = 1 << IDX_W;

    pte_t slot_q [SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                slot_q[i] <= '0;
            end
        end else if (we && (int'(widx) < PAGE_COUNT)) begin
            slot_q[widx] <= wpte;
        end
    end

    // Read ports see the state before this cycle's write.
    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        assign rpte[p] = slot_q[ridx[p]];
    end

endmodule

// File: rtl/aprm_regfile.sv
// Software-facing registers: control, slot select and indirect entry data.
module aprm_regfile
    import aprm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] APER_BASE  = 32'h4000_0000,
    parameter int                PAGE_COUNT = 32,
    parameter int                IDX_W      = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              xl_en,
    output logic              sel_in,
    output logic              tbl_we,
    output logic [IDX_W-1:0]  tbl_widx,
    output pte_t              tbl_wpte,
    output logic [IDX_W-1:0]  tbl_ridx,
    input  pte_t              tbl_rpte
);

    logic [ADDR_W-1:0] sel_q;
    logic              en_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_word;
    logic [IDX_W-1:0]  sel_idx;
    reg_sel_e          rsel;

    aprm_range #(
        .APER_BASE (APER_BASE),
        .PAGE_COUNT(PAGE_COUNT),
        .IDX_W     (IDX_W)
    ) u_sel_range (
        .addr   (sel_q),
        .in_aper(sel_in),
        .idx    (sel_idx)
    );

    assign rsel     = decode_reg(reg_addr);
    assign tbl_widx = sel_idx;
    assign tbl_ridx = sel_idx;
    assign tbl_wpte = word_to_pte(reg_wdata);
    // Entry writes through an out-of-aperture selection are dropped.
    assign tbl_we   = reg_we && (rsel == RSEL_ENTRY) && sel_in;

    always_comb begin
        rd_word = '0;
        case (rsel)
            RSEL_CTRL:  rd_word = {{(DATA_W-1){1'b0}}, en_q};
            RSEL_SLOT:  rd_word = sel_q;
            RSEL_ENTRY: rd_word = sel_in ? pte_to_word(tbl_rpte) : '0;
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            sel_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (reg_re) begin
                rdata_q <= rd_word;
            end
            if (reg_we) begin
                case (rsel)
                    RSEL_CTRL: en_q  <= reg_wdata[0];
                    RSEL_SLOT: sel_q <= reg_wdata;
                    default:   ;
                endcase
            end
        end
    end

    assign reg_rdata = rdata_q;
    assign xl_en     = en_q;

endmodule

// File: rtl/aprm_xlate.sv
// One-cycle translation stage.
module aprm_xlate
    import aprm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] APER_BASE  = 32'h4000_0000,
    parameter int                PAGE_COUNT = 32,
    parameter int                IDX_W      = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              xl_en,
    output logic [IDX_W-1:0]  tbl_ridx,
    input  pte_t              tbl_rpte,
    output xl_rsp_t           rsp
);

    logic    req_in;
    xl_rsp_t rsp_d;
    xl_rsp_t rsp_q;

    aprm_range #(
        .APER_BASE (APER_BASE),
        .PAGE_COUNT(PAGE_COUNT),
        .IDX_W     (IDX_W)
    ) u_req_range (
        .addr   (req_addr),
        .in_aper(req_in),
        .idx    (tbl_ridx)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (xl_en && req_in) begin
                if (tbl_rpte.valid) begin
                    rsp_d.hit  = 1'b1;
                    rsp_d.addr = join_frame(tbl_rpte.frame, req_addr[PAGE_SHIFT-1:0]);
                end else begin
                    rsp_d.fault = 1'b1;
                end
            end else begin
                rsp_d.addr = req_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp = rsp_q;

endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
    import aprm_pkg::*;
#(
    parameter logic [31:0] APER_BASE  = 32'h4000_0000,
    parameter int          PAGE_COUNT = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic        reg_re,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        rsp_valid,
    output logic [31:0] rsp_addr,
    output logic        rsp_hit,
    output logic        rsp_fault
);

    localparam int IDX_W  = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;
    localparam int RD_REG = 0;
    localparam int RD_XL  = 1;

    logic                    en_w;
    logic                    sel_in_w;
    logic                    tbl_we;
    logic [IDX_W-1:0]        tbl_widx;
    pte_t                    tbl_wpte;
    logic [1:0][IDX_W-1:0]   tbl_ridx;
    pte_t [1:0]              tbl_rpte;
    xl_rsp_t                 rsp_w;

    aprm_regfile #(
        .APER_BASE (APER_BASE),
        .PAGE_COUNT(PAGE_COUNT),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .xl_en    (en_w),
        .sel_in   (sel_in_w),
        .tbl_we   (tbl_we),
        .tbl_widx (tbl_widx),
        .tbl_wpte (tbl_wpte),
        .tbl_ridx (tbl_ridx[RD_REG]),
        .tbl_rpte (tbl_rpte[RD_REG])
    );

    aprm_table #(
        .PAGE_COUNT(PAGE_COUNT),
        .IDX_W     (IDX_W),
        .N_RD      (2)
    ) u_table (
        .clk (clk),
        .rst (rst),
        .we  (tbl_we),
        .widx(tbl_widx),
        .wpte(tbl_wpte),
        .ridx(tbl_ridx),
        .rpte(tbl_rpte)
    );

    aprm_xlate #(
        .APER_BASE (APER_BASE),
        .PAGE_COUNT(PAGE_COUNT),
        .IDX_W     (IDX_W)
    ) u_xlate (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .xl_en    (en_w),
        .tbl_ridx (tbl_ridx[RD_XL]),
        .tbl_rpte (tbl_rpte[RD_XL]),
        .rsp      (rsp_w)
    );

    assign rsp_valid = rsp_w.valid;
    assign rsp_addr  = rsp_w.addr;
    assign rsp_hit   = rsp_w.hit;
    assign rsp_fault = rsp_w.fault;

endmodule

// File: rtl/aprm_checker.sv
module aprm_checker #(
    parameter logic [31:0] APER_BASE  = 32'h4000_0000,
    parameter int          PAGE_COUNT = 32
) (
    input logic        clk,
    input logic        rst,
    input logic        reg_re,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_rdata,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic [31:0] rsp_addr,
    input logic        rsp_hit,
    input logic        rsp_fault,
    input logic        en_w,
    input logic        sel_in_w
);

    function automatic bit inside_ap(input logic [31:0] a);
        longint lo;
        longint hi;
        lo = longint'(APER_BASE);
        hi = lo + longint'(PAGE_COUNT) * 4096;
        return (longint'(a) >= lo) && (longint'(a) < hi);
    endfunction

    // R6: a response never claims both hit and fault
    assert_hit_fault_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(rsp_hit && rsp_fault));

    // R6: hit keeps the page offset of the request and clears bit 31
    assert_hit_offset_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_addr[11:0] == $past(req_addr[11:0])) && !rsp_addr[31]);

    // R7: a fault answer carries a zero address
    assert_fault_zero_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_addr == 32'h0));

    // R8: bypass when disabled or outside the aperture
    assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (!en_w || !inside_ap(req_addr))) |=>
            (rsp_addr == $past(req_addr)) && !rsp_hit && !rsp_fault);

    // R10: enabled in-aperture requests always resolve to hit or fault
    assert_in_aper_resolves_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && en_w && inside_ap(req_addr)) |=> (rsp_hit || rsp_fault));

    // R11: response valid follows request valid
    assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R11: idle response is all zero
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault && rsp_addr == 32'h0));

    // R5: entry read through an out-of-aperture selection returns zero
    assert_entry_oob_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_re && reg_addr == 8'h2C && !sel_in_w) |=> (reg_rdata == 32'h0));

    // R2: control read-back has only bit 0 live
    assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_re && reg_addr == 8'h24) |=> (reg_rdata[31:1] == 31'h0));

endmodule

bind aperture_remap aprm_checker #(
    .APER_BASE (APER_BASE),
    .PAGE_COUNT(PAGE_COUNT)
) u_aprm_checker (
    .clk      (clk),
    .rst      (rst),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .rsp_addr (rsp_addr),
    .rsp_hit  (rsp_hit),
    .rsp_fault(rsp_fault),
    .en_w     (en_w),
    .sel_in_w (sel_in_w)
);

// File: tb/aperture_remap_tb_top.sv
module aperture_remap_tb_top;

    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam int          N    = 32;
    localparam logic [31:0] TOP  = BASE + N * 4096;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic        reg_re;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic        rsp_hit;
    logic        rsp_fault;

    always #5 clk = ~clk;

    aperture_remap #(.APER_BASE(BASE), .PAGE_COUNT(N)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .rsp_valid(rsp_valid),
        .rsp_addr (rsp_addr),
        .rsp_hit  (rsp_hit),
        .rsp_fault(rsp_fault)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_tab [N];
    bit          m_en;
    logic [31:0] m_sel;
    logic [31:0] m_rdata;
    bit          m_rv, m_hit, m_fault;
    logic [31:0] m_raddr;
    int          ncyc = 0;
    int          compared = 0;
    int          mismatched = 0;
    bit          done = 0;
    string       cur_req = "R1";

    function automatic bit in_ap(input logic [31:0] a);
        return (longint'(a) >= longint'(BASE)) && (longint'(a) < longint'(TOP));
    endfunction

    function automatic int slot_of(input logic [31:0] a);
        return int'((a - BASE) >> 12);
    endfunction

    always @(posedge clk) begin
        logic [31:0] e;
        ncyc++;
        if (rst) begin
            foreach (m_tab[i]) m_tab[i] = '0;
            m_en = 0; m_sel = '0; m_rdata = '0;
            m_rv = 0; m_hit = 0; m_fault = 0; m_raddr = '0;
        end else begin
            // translation sees state before this edge's writes
            m_rv = req_valid; m_hit = 0; m_fault = 0; m_raddr = '0;
            if (req_valid) begin
                if (m_en && in_ap(req_addr)) begin
                    e = m_tab[slot_of(req_addr)];
                    if (e[31]) begin
                        m_hit = 1;
                        m_raddr = {1'b0, e[30:12], req_addr[11:0]};
                    end else begin
                        m_fault = 1;
                    end
                end else begin
                    m_raddr = req_addr;
                end
            end
            if (reg_re) begin
                case (reg_addr)
                    8'h24:   m_rdata = {31'h0, m_en};
                    8'h28:   m_rdata = m_sel;
                    8'h2C:   m_rdata = in_ap(m_sel) ? m_tab[slot_of(m_sel)] : 32'h0;
                    default: m_rdata = 32'h0;
                endcase
            end
            if (reg_we) begin
                case (reg_addr)
                    8'h24: m_en = reg_wdata[0];
                    8'h28: m_sel = reg_wdata;
                    8'h2C: if (in_ap(m_sel)) m_tab[slot_of(m_sel)] = {reg_wdata[31:12], 12'h000};
                    default: ;
                endcase
            end
        end
    end

    // Compare every cycle, 2 ns after the edge.
    always @(posedge clk) begin
        #2;
        if (!done) begin
            compared++;
            if (rsp_valid !== m_rv || rsp_addr !== m_raddr || rsp_hit !== m_hit ||
                rsp_fault !== m_fault || reg_rdata !== m_rdata) begin
                mismatched++;
                $display("FAIL %s @%0d: got v=%b a=%h h=%b f=%b rd=%h exp v=%b a=%h h=%b f=%b rd=%h",
                         cur_req, ncyc, rsp_valid, rsp_addr, rsp_hit, rsp_fault, reg_rdata,
                         m_rv, m_raddr, m_hit, m_fault, m_rdata);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d);
        cur_req = tag;
        reg_we = 1; reg_re = 0; reg_addr = a; reg_wdata = d; req_valid = 0;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        cur_req = tag;
        reg_we = 0; reg_re = 1; reg_addr = a; req_valid = 0;
        @(negedge clk);
        reg_re = 0;
    endtask

    task automatic xl(input string tag, input logic [31:0] a);
        cur_req = tag;
        reg_we = 0; reg_re = 0; req_valid = 1; req_addr = a;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic idle(input string tag);
        cur_req = tag;
        reg_we = 0; reg_re = 0; req_valid = 0;
        @(negedge clk);
    endtask

    task automatic map_page(input string tag, input int slot, input logic [31:0] d);
        wr(tag, 8'h28, BASE + slot * 4096);
        wr(tag, 8'h2C, d);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: got running exp finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1; reg_we = 0; reg_re = 0; reg_addr = '0; reg_wdata = '0;
        req_valid = 0; req_addr = '0;
        repeat (4) @(negedge clk);
        rst = 0;

        // R1: post-reset state observed through the ports
        idle("R1");
        rd("R1", 8'h24);
        rd("R1", 8'h28);
        for (int i = 0; i < N; i++) begin
            wr("R1", 8'h28, BASE + i * 4096);
            rd("R1", 8'h2C);
        end
        wr("R1", 8'h28, 32'h0);

        // R2: control register
        wr("R2", 8'h24, 32'h1);
        rd("R2", 8'h24);
        wr("R2", 8'h24, 32'hFFFF_FFFE);
        rd("R2", 8'h24);
        wr("R2", 8'h24, 32'h0000_0003);
        rd("R2", 8'h24);
        wr("R2", 8'h24, 32'h0);

        // R3: slot select read-back
        wr("R3", 8'h28, 32'hDEAD_BEEF);
        rd("R3", 8'h28);
        wr("R3", 8'h28, BASE + 32'h0000_5ABC);
        rd("R3", 8'h28);

        // R4: entry write/read with junk in low bits, unaligned select
        wr("R4", 8'h28, BASE + 32'h0000_3FFF);
        wr("R4", 8'h2C, 32'h8123_4FFF);
        rd("R4", 8'h2C);
        map_page("R4", 0, 32'h8000_1000);
        rd("R4", 8'h2C);
        map_page("R4", N - 1, 32'hFFFF_FABC);
        rd("R4", 8'h2C);
        map_page("R4", 7, 32'h0765_4321);
        rd("R4", 8'h2C);
        rd("R11", 8'h10);
        rd("R11", 8'h2D);

        // R8: disabled -> bypass even for mapped page
        xl("R8", BASE + 32'h123);
        xl("R8", 32'h1234_5678);

        // R6 / R7 with translation on
        wr("R6", 8'h24, 32'h1);
        xl("R6", BASE + 32'h0000_0ABC);
        xl("R6", BASE + 32'h0000_3001);
        xl("R7", BASE + 32'h0000_7010);
        xl("R7", BASE + 32'h0000_2000);
        xl("R8", 32'h0000_0FFF);
        xl("R8", 32'hFFFF_FFFF);

        // R10: aperture edges
        xl("R10", BASE);
        xl("R10", TOP - 1);
        xl("R10", BASE - 1);
        xl("R10", TOP);

        // R9: unmap by writing zero
        map_page("R9", 0, 32'h0);
        xl("R9", BASE + 32'h40);
        rd("R9", 8'h2C);

        // R5: out-of-aperture selection ignores writes, reads zero
        wr("R5", 8'h28, TOP);
        wr("R5", 8'h2C, 32'hFFFF_FFFF);
        rd("R5", 8'h2C);
        wr("R5", 8'h28, BASE - 32'h1000);
        wr("R5", 8'h2C, 32'h8000_F000);
        rd("R5", 8'h2C);
        for (int i = 0; i < N; i++) begin
            wr("R5", 8'h28, BASE + i * 4096);
            rd("R5", 8'h2C);
        end

        // R12: entry write colliding with a request to the same page
        map_page("R12", 5, 32'h8005_5000);
        cur_req = "R12";
        reg_we = 1; reg_addr = 8'h2C; reg_wdata = 32'h0;
        req_valid = 1; req_addr = BASE + 5 * 4096 + 32'h10;
        @(negedge clk);
        reg_we = 0;
        @(negedge clk);
        req_valid = 0;
        // R12: disable colliding with a request
        map_page("R12", 6, 32'h8006_6000);
        cur_req = "R12";
        reg_we = 1; reg_addr = 8'h24; reg_wdata = 32'h0;
        req_valid = 1; req_addr = BASE + 6 * 4096 + 32'h20;
        @(negedge clk);
        reg_we = 0;
        @(negedge clk);
        req_valid = 0;
        idle("R12");

        // R6: mixed random traffic, all ports at once
        for (int k = 0; k < 3000; k++) begin
            int r;
            cur_req = "R6";
            r = int'($urandom_range(0, 9));
            reg_we = (r < 4);
            reg_re = (r >= 3 && r < 7);
            case ($urandom_range(0, 4))
                0: reg_addr = 8'h24;
                1, 2: reg_addr = 8'h28;
                3: reg_addr = 8'h2C;
                default: reg_addr = 8'h20;
            endcase
            if (reg_addr == 8'h28)
                reg_wdata = ($urandom_range(0, 7) == 0) ? TOP + $urandom_range(0, 8191)
                                                         : BASE + $urandom_range(0, N * 4096 - 1);
            else if (reg_addr == 8'h24)
                reg_wdata = ($urandom_range(0, 3) == 0) ? 32'h0 : 32'h1;
            else
                reg_wdata = $urandom;
            req_valid = ($urandom_range(0, 2) != 0);
            case ($urandom_range(0, 5))
                0: req_addr = $urandom;
                1: req_addr = BASE - 32'($urandom_range(1, 16));
                2: req_addr = TOP + 32'($urandom_range(0, 16));
                default: req_addr = BASE + $urandom_range(0, N * 4096 - 1);
            endcase
            @(negedge clk);
        end
        idle("R11");
        idle("R11");

        done = 1;
        summary();
        $finish;
    end

endmodule